// File: doc/BRIEF.md
# Fabric Port Lane Sparing Controller

This block maps lanes for one full-duplex fabric port. The port has twenty serial lanes. Eighteen carry data. One carries the even parity of the eighteen data bits on every transfer. One is a spare. On the receive side the block rebuilds each 18-bit flit from the lanes and compares it with the parity lane. A flit that fails the comparison is dropped and the block asks for a link-level retry. On the transmit side the block spreads each outgoing word over the lanes, writes the parity lane, and fills the spare lane when a lane has been spared.

The block does not find the failing lane from parity alone. The retry replay reports which lane to blame. The block keeps a saturating counter for each data lane. When the same lane is blamed on a set number of replays in a row, that lane is marked hard-failed. The new mapping is committed only when the next replay starts, so no flit is ever assembled from two different mappings. Only one spare exists, so a second hard failure raises a fatal flag. The transmit mapping is loaded separately, from the far end's request, and it changes only at the start of a transmit replay.

Top module: `lane_spare_ctrl`

## Requirements
- R1: After synchronous reset, all of these read 0: `rx_data_valid`, `retry_req`, `retry_seen`, `spare_in_use`, `link_fatal` and `tx_lanes_valid`.
- R2: Lane layout on both directions:
  - Lanes 0..17 carry data bits 0..17.
  - Lane 18 carries the XOR of the 18 data bits (even parity).
  - Lane 19 is the spare.
- R3: A received flit whose parity check passes appears on `rx_data` with `rx_data_valid` high one clock after `rx_in_valid`. When no lane is spared, lane 19 has no effect on the received flit.
- R4: A received flit whose parity check fails is dropped. `rx_data_valid` stays low and `retry_req` pulses high one clock after the flit. This holds for an error on any data lane or on the parity lane.
- R5: `retry_seen` goes high one clock after the first `retry_req` pulse. It then stays high until reset.
- R6: A data lane becomes a pending hard failure after 4 blames in a row on that lane. A blame is `blame_valid` with `blame_lane`. A blame on any other data lane clears the run.
- R7: A pending failure is committed only on a `retry_start` cycle. Before that, `spare_in_use` stays 0. A `retry_start` with no pending failure changes nothing.
- R8: Once a lane is committed, `spare_in_use` reads 1 and `failed_lane` gives its index. After that, received data bit `failed_lane` is taken from lane 19. Its own lane is ignored.
- R9: A pending failure committed while the spare is already in use sets `link_fatal`. The flag is sticky. The existing mapping is kept.
- R10: A blame with `blame_lane` of 18 or more is ignored.
- R11: On transmit, `tx_lanes` and `tx_lanes_valid` follow `tx_in_valid` by one clock. Lane 18 holds the data parity. Lane 19 is 0 until a spare is active, and then it copies the data bit at the spared index.
- R12: `tx_spare_set` only stages a transmit spare index. That index becomes active on the next `tx_replay_start`. The transmit mapping and the receive mapping are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_lanes | input | 20 | Received bits, one per lane |
| rx_in_valid | input | 1 | `rx_lanes` holds a flit |
| rx_data | output | 18 | Rebuilt flit data |
| rx_data_valid | output | 1 | `rx_data` is a good flit |
| retry_req | output | 1 | One-cycle link-level retry request |
| retry_start | input | 1 | Replay begins; commits a pending spare |
| blame_valid | input | 1 | The replay blames a lane |
| blame_lane | input | 5 | Index of the blamed lane |
| retry_seen | output | 1 | Sticky: a retry has been requested |
| spare_in_use | output | 1 | Receive spare mapping is active |
| failed_lane | output | 5 | Receive lane replaced by the spare |
| link_fatal | output | 1 | Sticky: second hard failure |
| tx_data | input | 18 | Word to transmit |
| tx_in_valid | input | 1 | `tx_data` is valid |
| tx_spare_set | input | 1 | Stage a transmit spare index |
| tx_spare_lane | input | 5 | Transmit lane to spare |
| tx_replay_start | input | 1 | Transmit replay begins; activates the staged index |
| tx_lanes | output | 20 | Transmitted bits, one per lane |
| tx_lanes_valid | output | 1 | `tx_lanes` holds a word |

## Verification
The bench flips every one of the twenty receive lanes in turn.
- A design that skipped the parity lane, or that checked the spare lane while no lane was spared, would pass or drop the wrong flits.
- Broken runs of blames, blame counts one short of the limit, and a long wait before `retry_start` catch a design that counts total blames instead of blames in a row, or that commits early.
- Blames on out-of-range lanes catch a design that accepts them.
- A second failure catches a design that overwrites the spare mapping instead of raising the fatal flag.
- A transmit spare set to a different lane from the receive spare catches a design that shares one mapping register between the two directions.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned DATA_LANES = 18;
  localparam int unsigned PAR_LANE   = DATA_LANES;
  localparam int unsigned SPARE_LANE = DATA_LANES + 1;
  localparam int unsigned LANES      = DATA_LANES + 2;
  localparam int unsigned IDX_W      = $clog2(LANES);

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
  } spare_map_t;
endpackage

// File: rtl/lsc_rx_path.sv
module lsc_rx_path
  import lsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES-1:0]      lanes_i,
  input  logic                  valid_i,
  input  spare_map_t            map_i,
  output logic [DATA_LANES-1:0] data_o,
  output logic                  valid_o,
  output logic                  retry_o
);
  logic [DATA_LANES-1:0] steered;
  logic                  par_bad;

  // Put the spare lane in place of the failed data lane.
  for (genvar i = 0; i < DATA_LANES; i++) begin : g_steer
    assign steered[i] = (map_i.vld && map_i.idx == IDX_W'(i)) ?
                        lanes_i[SPARE_LANE] : lanes_i[i];
  end

  assign par_bad = (^steered) ^ lanes_i[PAR_LANE];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      retry_o <= 1'b0;
    end else begin
      valid_o <= valid_i & ~par_bad;
      retry_o <= valid_i & par_bad;
      if (valid_i && !par_bad) data_o <= steered;
    end
  end

  // R3: a delivered flit matches the parity lane that came with it
  a_r3_parity_ok: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((^data_o) == $past(lanes_i[PAR_LANE])));
  // R4: a retry request only follows a received flit
  a_r4_retry_has_flit: assert property (@(posedge clk) disable iff (rst)
    retry_o |-> $past(valid_i));
endmodule

// File: rtl/lsc_fail_tracker.sv
module lsc_fail_tracker
  import lsc_pkg::*;
#(
  parameter int unsigned FAIL_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blame_valid_i,
  input  logic [IDX_W-1:0] blame_lane_i,
  input  logic             retry_start_i,
  output spare_map_t       map_o,
  output logic             fatal_o
);
  localparam int unsigned CNT_W = $clog2(FAIL_LIMIT + 1);

  logic [CNT_W-1:0]      cnt [DATA_LANES];
  logic [DATA_LANES-1:0] lane_hit;
  logic                  blame_ok;
  logic                  hit_limit;
  logic                  pend;
  logic [IDX_W-1:0]      pend_idx;
  logic                  commit;

  assign blame_ok  = blame_valid_i && (blame_lane_i < IDX_W'(DATA_LANES));
  assign commit    = retry_start_i && pend;
  assign hit_limit = |lane_hit;

  for (genvar i = 0; i < DATA_LANES; i++) begin : g_cnt
    assign lane_hit[i] = blame_ok && blame_lane_i == IDX_W'(i) &&
                         cnt[i] == CNT_W'(FAIL_LIMIT - 1);

    always_ff @(posedge clk) begin
      if (rst || commit) begin
        cnt[i] <= '0;
      end else if (blame_ok) begin
        if (blame_lane_i == IDX_W'(i)) begin
          if (cnt[i] != CNT_W'(FAIL_LIMIT)) cnt[i] <= cnt[i] + 1'b1;
        end else begin
          cnt[i] <= '0;
        end
      end
    end

    // R6: the run counter saturates at the limit
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt[i] <= CNT_W'(FAIL_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_idx <= '0;
      map_o    <= '0;
      fatal_o  <= 1'b0;
    end else begin
      if (hit_limit) begin
        pend     <= 1'b1;
        pend_idx <= blame_lane_i;
      end else if (retry_start_i) begin
        pend <= 1'b0;
      end
      if (commit) begin
        if (!map_o.vld) map_o <= '{vld: 1'b1, idx: pend_idx};
        else            fatal_o <= 1'b1;
      end
    end
  end

  // R7: the mapping appears only on a replay start
  a_r7_commit_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(map_o.vld) |-> $past(retry_start_i));
  // R8: a committed mapping never moves
  a_r8_map_hold: assert property (@(posedge clk) disable iff (rst)
    map_o.vld |=> (map_o.vld && $stable(map_o.idx)));
  // R9: the fatal flag is sticky and needs an active spare
  a_r9_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
    fatal_o |=> fatal_o);
  a_r9_fatal_needs_spare: assert property (@(posedge clk) disable iff (rst)
    $rose(fatal_o) |-> map_o.vld);
endmodule

// File: rtl/lsc_tx_path.sv
module lsc_tx_path
  import lsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DATA_LANES-1:0] data_i,
  input  logic                  valid_i,
  input  logic                  spare_set_i,
  input  logic [IDX_W-1:0]      spare_lane_i,
  input  logic                  replay_start_i,
  output logic [LANES-1:0]      lanes_o,
  output logic                  valid_o
);
  spare_map_t            staged;
  spare_map_t            active;
  logic [DATA_LANES-1:0] pick;
  logic                  spare_bit;

  for (genvar i = 0; i < DATA_LANES; i++) begin : g_pick
    assign pick[i] = active.vld && active.idx == IDX_W'(i) && data_i[i];
  end
  assign spare_bit = |pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
      active <= '0;
    end else begin
      if (spare_set_i && spare_lane_i < IDX_W'(DATA_LANES))
        staged <= '{vld: 1'b1, idx: spare_lane_i};
      if (replay_start_i && staged.vld) active <= staged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lanes_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) lanes_o <= {spare_bit, ^data_i, data_i};
    end
  end

  // R12: the transmit spare becomes active only on a transmit replay start
  a_r12_tx_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(active.vld) |-> $past(replay_start_i));
  // R11: the spare lane is idle on a word sent before any spare was active
  a_r11_spare_idle: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !$past(active.vld)) |-> !lanes_o[SPARE_LANE]);
endmodule

// File: rtl/lane_spare_ctrl.sv
module lane_spare_ctrl
  import lsc_pkg::*;
#(
  parameter int unsigned FAIL_LIMIT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES-1:0]      rx_lanes,
  input  logic                  rx_in_valid,
  output logic [DATA_LANES-1:0] rx_data,
  output logic                  rx_data_valid,
  output logic                  retry_req,
  input  logic                  retry_start,
  input  logic                  blame_valid,
  input  logic [IDX_W-1:0]      blame_lane,
  output logic                  retry_seen,
  output logic                  spare_in_use,
  output logic [IDX_W-1:0]      failed_lane,
  output logic                  link_fatal,
  input  logic [DATA_LANES-1:0] tx_data,
  input  logic                  tx_in_valid,
  input  logic                  tx_spare_set,
  input  logic [IDX_W-1:0]      tx_spare_lane,
  input  logic                  tx_replay_start,
  output logic [LANES-1:0]      tx_lanes,
  output logic                  tx_lanes_valid
);
  spare_map_t rx_map;

  lsc_rx_path u_rx (
    .clk(clk), .rst(rst), .lanes_i(rx_lanes), .valid_i(rx_in_valid),
    .map_i(rx_map), .data_o(rx_data), .valid_o(rx_data_valid),
    .retry_o(retry_req)
  );

  lsc_fail_tracker #(.FAIL_LIMIT(FAIL_LIMIT)) u_track (
    .clk(clk), .rst(rst), .blame_valid_i(blame_valid),
    .blame_lane_i(blame_lane), .retry_start_i(retry_start),
    .map_o(rx_map), .fatal_o(link_fatal)
  );

  lsc_tx_path u_tx (
    .clk(clk), .rst(rst), .data_i(tx_data), .valid_i(tx_in_valid),
    .spare_set_i(tx_spare_set), .spare_lane_i(tx_spare_lane),
    .replay_start_i(tx_replay_start), .lanes_o(tx_lanes),
    .valid_o(tx_lanes_valid)
  );

  assign spare_in_use = rx_map.vld;
  assign failed_lane  = rx_map.idx;

  always_ff @(posedge clk) begin
    if (rst) retry_seen <= 1'b0;
    else     retry_seen <= retry_seen | retry_req;
  end

  // R5: the retry flag follows a request and then holds
  a_r5_seen_follows: assert property (@(posedge clk) disable iff (rst)
    retry_req |=> retry_seen);
  a_r5_seen_sticky: assert property (@(posedge clk) disable iff (rst)
    retry_seen |=> retry_seen);
endmodule

// File: tb/lane_spare_ctrl_bench.sv
module lane_spare_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] rx_lanes = '0;
  logic        rx_in_valid = 1'b0;
  logic [17:0] rx_data;
  logic        rx_data_valid, retry_req, retry_seen, spare_in_use, link_fatal;
  logic        retry_start = 1'b0, blame_valid = 1'b0;
  logic [4:0]  blame_lane = '0, failed_lane, tx_spare_lane = '0;
  logic [17:0] tx_data = '0;
  logic        tx_in_valid = 1'b0, tx_spare_set = 1'b0, tx_replay_start = 1'b0;
  logic [19:0] tx_lanes;
  logic        tx_lanes_valid;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  lane_spare_ctrl u_lane_spare_ctrl (
    .clk(clk), .rst(rst), .rx_lanes(rx_lanes), .rx_in_valid(rx_in_valid),
    .rx_data(rx_data), .rx_data_valid(rx_data_valid), .retry_req(retry_req),
    .retry_start(retry_start), .blame_valid(blame_valid),
    .blame_lane(blame_lane), .retry_seen(retry_seen),
    .spare_in_use(spare_in_use), .failed_lane(failed_lane),
    .link_fatal(link_fatal), .tx_data(tx_data), .tx_in_valid(tx_in_valid),
    .tx_spare_set(tx_spare_set), .tx_spare_lane(tx_spare_lane),
    .tx_replay_start(tx_replay_start), .tx_lanes(tx_lanes),
    .tx_lanes_valid(tx_lanes_valid)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Builds the lane word from the R2 layout. brk inverts the spared lane.
  function automatic logic [19:0] enc(input logic [17:0] d, input bit use_sp,
                                      input int idx, input bit brk);
    logic [19:0] w;
    w = {1'b0, ^d, d};
    if (use_sp) w[19] = d[idx];
    if (brk) w[idx] = ~w[idx];
    return w;
  endfunction

  function automatic logic [17:0] pat(input int k);
    return 18'((k * 40503 + 7919) % 262144);
  endfunction

  task automatic blame(input int lane, input int n);
    for (int i = 0; i < n; i++) begin
      blame_valid = 1'b1;
      blame_lane  = 5'(lane);
      tick();
    end
    blame_valid = 1'b0;
  endtask

  task automatic replay();
    retry_start = 1'b1;
    tick();
    retry_start = 1'b0;
    tick();
  endtask

  task automatic rx_flit(input logic [19:0] w);
    rx_in_valid = 1'b1;
    rx_lanes    = w;
    tick();
    rx_in_valid = 1'b0;
  endtask

  task automatic tx_word(input logic [17:0] d);
    tx_in_valid = 1'b1;
    tx_data     = d;
    tick();
    tx_in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    rst = 1'b0;
    tick();
    check("R1 rx valid", 32'(rx_data_valid), 0);
    check("R1 retry", 32'(retry_req), 0);
    check("R1 seen", 32'(retry_seen), 0);
    check("R1 spare", 32'(spare_in_use), 0);
    check("R1 fatal", 32'(link_fatal), 0);
    check("R1 tx valid", 32'(tx_lanes_valid), 0);

    // R3: clean flits pass, including with junk on the idle spare lane
    for (int k = 0; k < 16; k++) begin
      logic [19:0] w;
      w = enc(pat(k), 1'b0, 0, 1'b0);
      w[19] = k[0];
      rx_flit(w);
      check("R3 valid", 32'(rx_data_valid), 1);
      check("R3 data", 32'(rx_data), 32'(pat(k)));
      check("R3 no retry", 32'(retry_req), 0);
    end
    check("R5 seen before error", 32'(retry_seen), 0);

    // R4: flip each lane in turn; only the unused spare lane is harmless
    for (int l = 0; l < 20; l++) begin
      logic [19:0] w;
      w = enc(pat(l + 3), 1'b0, 0, 1'b0);
      w[l] = ~w[l];
      rx_flit(w);
      check("R4 retry", 32'(retry_req), (l < 19) ? 1 : 0);
      check("R4 dropped", 32'(rx_data_valid), (l < 19) ? 0 : 1);
    end
    tick();
    check("R5 seen", 32'(retry_seen), 1);

    // R6 and R7: runs that are broken or too short never commit
    blame(5, 3);
    blame(7, 1);
    blame(5, 3);
    replay();
    check("R6 broken run", 32'(spare_in_use), 0);
    blame(5, 1);
    tick();
    tick();
    check("R7 no commit before start", 32'(spare_in_use), 0);
    replay();
    check("R8 spare used", 32'(spare_in_use), 1);
    check("R8 failed lane", 32'(failed_lane), 5);

    // R8: lane 5 is broken, so its bit comes from the spare lane
    for (int k = 0; k < 12; k++) begin
      rx_flit(enc(pat(k + 40), 1'b1, 5, 1'b1));
      check("R8 spared valid", 32'(rx_data_valid), 1);
      check("R8 spared data", 32'(rx_data), 32'(pat(k + 40)));
    end

    // R10: out-of-range blames are ignored
    blame(18, 4);
    blame(25, 4);
    replay();
    check("R10 no fatal", 32'(link_fatal), 0);
    check("R10 lane kept", 32'(failed_lane), 5);

    // R9: second hard failure
    blame(9, 4);
    replay();
    check("R9 fatal", 32'(link_fatal), 1);
    check("R9 lane kept", 32'(failed_lane), 5);
    check("R9 spare kept", 32'(spare_in_use), 1);

    // R11: transmit without spare
    for (int k = 0; k < 12; k++) begin
      tx_word(pat(k + 80));
      check("R11 tx valid", 32'(tx_lanes_valid), 1);
      check("R11 tx lanes", 32'(tx_lanes), 32'(enc(pat(k + 80), 1'b0, 0, 1'b0)));
    end

    // R12: a staged index is not active until the transmit replay
    tx_spare_set  = 1'b1;
    tx_spare_lane = 5'd3;
    tick();
    tx_spare_set = 1'b0;
    tx_word(18'h3ffff);
    check("R12 staged only", 32'(tx_lanes[19]), 0);
    tx_replay_start = 1'b1;
    tick();
    tx_replay_start = 1'b0;
    for (int k = 0; k < 12; k++) begin
      tx_word(pat(k + 120));
      check("R12 tx spared", 32'(tx_lanes), 32'(enc(pat(k + 120), 1'b1, 3, 1'b0)));
    end
    check("R12 rx map apart", 32'(failed_lane), 5);
    rx_flit(enc(pat(200), 1'b1, 5, 1'b1));
    check("R12 rx still lane 5", 32'(rx_data), 32'(pat(200)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule